// File: doc/BRIEF.md
# Byte-wide configuration port receiver

This block sits on the device side of a byte-wide configuration port driven by an external host. On each rising edge of the configuration clock it looks at the host's active-low write strobe and two active-low chip selects. When the strobe is asserted, both selects are low and the block is idle, it takes the byte on the data bus. It then raises a BUSY handshake so the host knows it must hold off while the byte is processed.

Each accepted byte leaves the block on a valid/ready stream in arrival order. The stream obeys the usual rule: once `out_valid` is high, `out_data` stays fixed until a clock edge at which `out_ready` is also high. A consumer that holds `out_ready` low applies back-pressure. The block keeps BUSY high for as long as a byte is waiting, so the stall reaches the host instead of dropping data.

After a parameterised number of bytes the block raises a sticky completion flag and refuses further bytes. A synchronous active-low program input returns it to its initial state.

Top module: `cfgrx_parallel_rx`

## Requirements
- R1: At a rising edge of `cfg_clk` where `wr_n`=0, `cs_a_n`=0, `cs_b_n`=0, `busy`=0 and `cfg_done`=0, the byte on `din` is accepted. It appears on `out_data` with `out_valid`=1 in the following cycle.
- R2: With `out_ready` held high, `busy` is high for exactly PROC_CYCLES (default 2) cycles after an accepting edge, then returns low.
- R3: A byte presented with `wr_n`=0 while `busy` is high is ignored, and no stream beat is produced for it.
- R4: While either `cs_a_n` or `cs_b_n` is high, no byte is accepted, whatever the state of `wr_n`.
- R5: Once both chip selects return low with `wr_n`=0 and `busy`=0, acceptance resumes at the next edge.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold steady and `busy` stays high. A beat completes at an edge where both are high.
- R7: Stream beats carry the accepted bytes in the order they were received.
- R8: `cfg_done` rises together with the beat of the TOTAL_BYTES-th accepted byte (default 16) and stays high until `prog_n` is low. While it is high, no byte is accepted.
- R9: A rising edge with `prog_n`=0 clears the byte count, `busy`, `out_valid` and `cfg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| prog_n | input | 1 | Synchronous active-low program/reset |
| wr_n | input | 1 | Active-low write strobe from host |
| cs_a_n | input | 1 | First active-low chip select |
| cs_b_n | input | 1 | Second active-low chip select |
| din | input | DATA_W | Host data bus |
| busy | output | 1 | High while a byte is being processed or waits on the stream |
| cfg_done | output | 1 | Sticky completion flag |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | DATA_W | Stream beat data |

## Verification
On every cycle, the assertions check the following:
- a beat only starts after an edge where the strobe and both selects were asserted and `busy` was low;
- `busy` is high once a beat starts;
- a stalled beat holds its data;
- completion is sticky and blocks further beats;
- program clears the outputs;
- the busy period never runs longer than the processing count.

Only the bench's scenarios can show the rest. These are: the exact busy length, that a byte held through BUSY or behind a raised select is not taken, that transfer resumes when the selects drop, the byte order, and that program restarts the byte count so completion lands on the right byte again.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  // Number of chip-select inputs qualifying a write.
  localparam int unsigned SEL_COUNT = 2;

  // Width needed to count from 0 up to n inclusive.
  function automatic int unsigned count_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cfgrx_gate.sv
module cfgrx_gate #(
  parameter int unsigned NUM_SEL = 2
) (
  input  logic               wr_n,
  input  logic [NUM_SEL-1:0] sel_n,
  input  logic               busy,
  input  logic               halted,
  output logic               accept
);
  logic [NUM_SEL-1:0] sel_on;

  // Each select contributes one active-high enable term.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign sel_on[g] = ~sel_n[g];
  end

  always_comb begin
    accept = ~wr_n & (&sel_on) & ~busy & ~halted;
  end
endmodule

// File: rtl/cfgrx_pace.sv
module cfgrx_pace #(
  parameter int unsigned PROC_CYCLES = 2
) (
  input  logic clk,
  input  logic prog_n,
  input  logic load,
  output logic active
);
  localparam int unsigned W = cfgrx_pkg::count_w(PROC_CYCLES);
  localparam logic [W-1:0] LOAD_V = W'(PROC_CYCLES);

  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!prog_n)               left_q <= '0;
    else if (load)             left_q <= LOAD_V;
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/cfgrx_tally.sv
module cfgrx_tally #(
  parameter int unsigned TOTAL_BYTES = 16
) (
  input  logic clk,
  input  logic prog_n,
  input  logic incr,
  output logic done
);
  localparam int unsigned W = cfgrx_pkg::count_w(TOTAL_BYTES);
  localparam logic [W-1:0] LAST_V = W'(TOTAL_BYTES - 1);

  logic [W-1:0] seen_q;
  logic         done_q;

  always_ff @(posedge clk) begin
    if (!prog_n) begin
      seen_q <= '0;
      done_q <= 1'b0;
    end else if (incr) begin
      seen_q <= seen_q + 1'b1;
      if (seen_q == LAST_V) done_q <= 1'b1;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/cfgrx_outreg.sv
module cfgrx_outreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              prog_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!prog_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (capture) begin
      valid_q <= 1'b1;
      data_q  <= cap_data;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
endmodule

// File: rtl/cfgrx_parallel_rx.sv
module cfgrx_parallel_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROC_CYCLES = 2,
  parameter int unsigned TOTAL_BYTES = 16
) (
  input  logic              cfg_clk,
  input  logic              prog_n,
  input  logic              wr_n,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              cfg_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned NSEL = cfgrx_pkg::SEL_COUNT;

  logic [NSEL-1:0] sel_n;
  logic            accept;
  logic            proc_active;

  assign sel_n = {cs_b_n, cs_a_n};

  // A waiting beat keeps the host stalled, as does processing.
  assign busy = proc_active | out_valid;

  cfgrx_gate #(.NUM_SEL(NSEL)) u_gate (
    .wr_n   (wr_n),
    .sel_n  (sel_n),
    .busy   (busy),
    .halted (cfg_done),
    .accept (accept)
  );

  cfgrx_pace #(.PROC_CYCLES(PROC_CYCLES)) u_pace (
    .clk    (cfg_clk),
    .prog_n (prog_n),
    .load   (accept),
    .active (proc_active)
  );

  cfgrx_tally #(.TOTAL_BYTES(TOTAL_BYTES)) u_tally (
    .clk    (cfg_clk),
    .prog_n (prog_n),
    .incr   (accept),
    .done   (cfg_done)
  );

  cfgrx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk      (cfg_clk),
    .prog_n   (prog_n),
    .capture  (accept),
    .cap_data (din),
    .ready    (out_ready),
    .valid    (out_valid),
    .data     (out_data)
  );
endmodule

// File: rtl/cfgrx_checker.sv
module cfgrx_checker #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROC_CYCLES = 2
) (
  input logic              cfg_clk,
  input logic              prog_n,
  input logic              wr_n,
  input logic              cs_a_n,
  input logic              cs_b_n,
  input logic              busy,
  input logic              cfg_done,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  int unsigned busy_run;

  always_ff @(posedge cfg_clk) begin
    if (!prog_n)                 busy_run <= 0;
    else if (busy && !out_valid) busy_run <= busy_run + 1;
    else                         busy_run <= 0;
  end

  AST_BEAT_NEEDS_WRITE: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    $rose(out_valid) |-> $past(!wr_n && !cs_a_n && !cs_b_n && !busy)); // R1
  AST_BUSY_ON_BEAT: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    $rose(out_valid) |-> busy); // R2
  AST_BUSY_BOUNDED: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    busy_run <= PROC_CYCLES); // R2
  AST_STALL_HOLDS: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && busy)); // R6
  AST_DONE_STICKY: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    cfg_done |=> cfg_done); // R8
  AST_DONE_BLOCKS: assert property (@(posedge cfg_clk) disable iff (!prog_n)
    cfg_done |=> !$rose(out_valid)); // R8
  AST_PROGRAM_CLEARS: assert property (@(posedge cfg_clk)
    !prog_n |=> (!busy && !cfg_done && !out_valid)); // R9
endmodule

bind cfgrx_parallel_rx cfgrx_checker #(.DATA_W(DATA_W), .PROC_CYCLES(PROC_CYCLES)) u_chk (
  .cfg_clk   (cfg_clk),
  .prog_n    (prog_n),
  .wr_n      (wr_n),
  .cs_a_n    (cs_a_n),
  .cs_b_n    (cs_b_n),
  .busy      (busy),
  .cfg_done  (cfg_done),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_cfgrx_parallel_rx.sv
`timescale 1ns/1ps
module test_cfgrx_parallel_rx;
  localparam int DW = 8;
  localparam int PROC = 2;
  localparam int TOTAL = 16;

  logic clk = 1'b0;
  logic prog_n = 1'b0, wr_n = 1'b1, cs_a_n = 1'b1, cs_b_n = 1'b1, out_ready = 1'b1;
  logic [DW-1:0] din = '0;
  logic busy, cfg_done, out_valid;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk; // 125 MHz

  cfgrx_parallel_rx #(.DATA_W(DW), .PROC_CYCLES(PROC), .TOTAL_BYTES(TOTAL)) i_cfgrx_parallel_rx (
    .cfg_clk(clk), .prog_n(prog_n), .wr_n(wr_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .din(din), .busy(busy), .cfg_done(cfg_done), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  int checks = 0, errors = 0, cycles = 0;
  bit armed = 0;

  // Behavioural reference model
  int m_left = 0, m_count = 0;
  bit m_valid = 0, m_done = 0;
  logic [DW-1:0] exp_q[$];

  always @(posedge clk) begin
    bit m_busy, take;
    if (!prog_n) begin
      m_left = 0; m_count = 0; m_valid = 0; m_done = 0; exp_q.delete();
    end else begin
      m_busy = (m_left > 0) || m_valid;
      take = !wr_n && !cs_a_n && !cs_b_n && !m_busy && !m_done;
      if (m_valid && out_ready) begin m_valid = 0; void'(exp_q.pop_front()); end
      if (m_left > 0) m_left--;
      if (take) begin
        m_valid = 1; m_left = PROC; exp_q.push_back(din);
        m_count++;
        if (m_count == TOTAL) m_done = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      check(busy == ((m_left > 0) || m_valid), "R2 busy vs model", busy, (m_left > 0) || m_valid);
      check(out_valid == m_valid, "R6 out_valid vs model", out_valid, m_valid);
      check(cfg_done == m_done, "R8 cfg_done vs model", cfg_done, m_done);
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R7 beat with nothing expected", out_data, 0);
        else check(out_data == exp_q[0], "R7 out_data order", out_data, exp_q[0]);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic put(input logic [DW-1:0] b);
    din = b; wr_n = 0; cs_a_n = 0; cs_b_n = 0;
  endtask

  task automatic send(input logic [DW-1:0] b);
    while (busy) tick();
    put(b);
    tick();
    wr_n = 1;
  endtask

  initial begin
    repeat (3) tick();
    prog_n = 1; armed = 1;
    tick();
    check(!busy && !cfg_done && !out_valid, "R9 reset state", {busy, cfg_done, out_valid}, 0);

    // Single byte and busy length
    send(8'hA5);
    check(out_valid && out_data == 8'hA5, "R1 byte accepted", out_data, 8'hA5);
    check(busy == 1, "R2 busy after accept", busy, 1);
    repeat (PROC - 1) tick();
    check(busy == 1, "R2 busy at last processing cycle", busy, 1);
    tick();
    check(busy == 0, "R2 busy released", busy, 0);

    // Byte presented during busy is ignored
    send(8'h11);
    put(8'h22);
    repeat (PROC) tick();
    wr_n = 1;
    tick();
    check(out_valid == 0, "R3 byte during busy ignored", out_valid, 0);
    tick();
    check(out_valid == 0, "R3 no late beat", out_valid, 0);

    // Chip-select pause and resume
    put(8'h44); cs_a_n = 1;
    repeat (3) begin tick(); check(out_valid == 0, "R4 first select high", out_valid, 0); end
    cs_a_n = 0; cs_b_n = 1;
    repeat (3) begin tick(); check(out_valid == 0, "R4 second select high", out_valid, 0); end
    cs_b_n = 0;
    tick();
    wr_n = 1;
    check(out_valid && out_data == 8'h44, "R5 resumed after selects low", out_data, 8'h44);

    // Back-pressure
    while (busy) tick();
    out_ready = 0;
    send(8'h55);
    repeat (5) begin
      tick();
      check(out_valid && out_data == 8'h55 && busy, "R6 stalled beat held", out_data, 8'h55);
    end
    out_ready = 1;
    tick();
    check(out_valid == 0, "R6 beat drained", out_valid, 0);

    // Stream to completion (4 bytes so far)
    for (int i = 0; i < TOTAL - 4; i++) begin
      if (i == TOTAL - 5) check(cfg_done == 0, "R8 not done before last byte", cfg_done, 0);
      send(8'(i * 37 + 3));
    end
    check(cfg_done && out_valid, "R8 done with last beat", {cfg_done, out_valid}, 3);
    put(8'h99);
    repeat (6) begin tick(); check(out_valid == 0 && cfg_done, "R8 ignored after done", out_valid, 0); end
    wr_n = 1;

    // Program clears everything, including mid-processing
    prog_n = 0; tick(); prog_n = 1; tick();
    check(!busy && !cfg_done && !out_valid, "R9 program clears", {busy, cfg_done, out_valid}, 0);
    send(8'h66);
    prog_n = 0; tick(); prog_n = 1;
    check(!busy && !out_valid, "R9 program during busy", {busy, out_valid}, 0);
    for (int i = 0; i < TOTAL; i++) begin
      if (i == TOTAL - 1) check(cfg_done == 0, "R9 count restarted", cfg_done, 0);
      send(8'(255 - i * 11));
    end
    check(cfg_done == 1, "R8 done after full count again", cfg_done, 1);
    repeat (4) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule